// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Queue

This block is the receive half of a memory-mapped asynchronous serial port. It takes the serial input, or the transmitter's own line when loopback is on, and samples it on a strobe that fires sixteen times per bit. It checks the start bit at its centre, shifts in eight data bits least significant bit first, checks an optional parity bit, and then checks the stop bit. Each finished character enters an eight-entry queue together with its own parity and framing verdicts.

Software reads the status of the character at the head of the queue, which is its data, its parity error flag and its framing error flag, and then pops it. If a character finishes while the queue is full, a sticky overrun flag is set. From then on every new character is dropped. A pulse on the overrun-clear input clears the flag and empties the queue. A level interrupt is raised when the queue fill reaches a threshold chosen by a two-bit select.

Top module: `uart_rx_errq`

## Requirements
- R1: After reset, data_avail, overrun, parity_err, frame_err and rx_irq are all 0.
- R2: A frame is received as a low start bit, eight data bits least significant bit first, an optional parity bit and a high stop bit. Each bit lasts 16 os_tick strobes. data_avail is 1 exactly while the queue holds at least one character.
- R3: A low level that has gone high again by the eighth strobe after it was first seen is ignored, and no character is stored.
- R4: par_sel selects the parity mode: 00 none, 01 even, 10 odd, 11 none. When parity is on, a character whose parity bit does not match carries parity_err = 1, and one whose parity bit matches carries parity_err = 0.
- R5: A character whose stop bit is sampled low carries frame_err = 1 and keeps its data.
- R6: rx_data, parity_err and frame_err describe the head character. A pulse on rd_pop removes it, and the next character then takes its place in order. When the queue is empty, both error flags read 0.
- R7: The queue holds 8 characters. A character that finishes while the queue is full sets overrun, is dropped, and leaves the stored characters unchanged.
- R8: While overrun is 1, every character that finishes is dropped, even if the queue has room.
- R9: A pulse on ovf_clr clears overrun and empties the queue. Reception then resumes.
- R10: While rx_en is 0, nothing is received and any frame in progress is abandoned.
- R11: When lb_en is 1 the receiver takes its input from lb_tx and rx_pin has no effect.
- R12: irq_sel sets the fill level at which rx_irq goes high: 00 at 1 or more (any character), 01 at DEPTH/2 or more, 10 at 3·DEPTH/4 or more, 11 when full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| rx_pin | input | 1 | Serial input from the pad, idle high |
| lb_en | input | 1 | Loopback select: 1 takes the input from lb_tx |
| lb_tx | input | 1 | Transmitter output line used in loopback |
| rx_en | input | 1 | Receive enable |
| par_sel | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| irq_sel | input | 2 | Interrupt fill threshold select |
| rd_pop | input | 1 | Pop the head character |
| ovf_clr | input | 1 | Clear overrun and flush the queue |
| rx_data | output | 8 | Data of the head character (0 when empty) |
| data_avail | output | 1 | Queue holds at least one character |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Parity error of the head character |
| frame_err | output | 1 | Framing error of the head character |
| rx_irq | output | 1 | Receive interrupt, a level |

## Verification
The bench sends a short low pulse in front of a real frame. A receiver that started on an edge without checking the centre of the start bit would then store a stray 0xFF. The bench queues a good character and a bad one in even parity mode and then in odd mode, and pops them in between. A design that kept one global error flag, or that applied the flags to the wrong entry, would report the bad verdict on the good character. The bench fills the queue, overflows it, frees one slot and sends again. A design that only checked whether the queue was full, and not the sticky flag, would store that late character. A design that cleared the flag without flushing would leave stale entries behind. A frame is also sent with rx_pin held low while loopback is on, so a broken input mux would produce garbage.

// File: rtl/uart_rx_errq_pkg.sv
// Package: types shared by the receiver, its queue and its checker.
// Assumes eight data bits per character.
package uart_rx_errq_pkg;

    // Receiver frame state
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_t;

    // One queued character with its own verdicts
    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_char_t;

    localparam int CHAR_W = $bits(rx_char_t);

endpackage

// File: rtl/uart_rx_errq_shift.sv
// Module: frame deserializer. It synchronizes the line, checks the start bit
// at its centre, shifts data in LSB first, checks parity and the stop bit,
// and gives a one-cycle done pulse with the finished character.
// Assumes os_tick fires OVS times per bit and that the line idles high.
module uart_rx_errq_shift
    import uart_rx_errq_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int DATA_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rx_en,
    input  logic       line_raw,
    input  logic [1:0] par_sel,
    output logic       done,
    output rx_char_t   chr
);
    localparam int CW = $clog2(OVS);
    localparam int BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CW-1:0] TC_MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] TC_LAST = CW'(OVS - 1);
    localparam logic [BW-1:0] B_LAST  = BW'(DATA_BITS - 1);

    logic [1:0]           sync_q;
    logic                 line;
    rx_state_t            state;
    logic [CW-1:0]        tcnt;
    logic [BW-1:0]        bidx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;
    logic                 par_on;
    logic                 par_odd;

    assign line    = sync_q[1];
    assign par_on  = (par_sel == 2'b01) || (par_sel == 2'b10);
    assign par_odd = (par_sel == 2'b10);

    // Two-flop synchronizer for the asynchronous line, resetting to idle high
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_raw};
    end

    // Frame state machine, advanced on each oversampling strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            chr     <= '0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state <= ST_IDLE;
                tcnt  <= '0;
            end else if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            tcnt  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt == TC_MID) begin
                            tcnt  <= '0;
                            bidx  <= '0;
                            state <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt == TC_LAST) begin
                            tcnt  <= '0;
                            shreg <= {line, shreg[DATA_BITS-1:1]};
                            bidx  <= bidx + 1'b1;
                            if (bidx == B_LAST) state <= par_on ? ST_PAR : ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (tcnt == TC_LAST) begin
                            tcnt    <= '0;
                            par_bit <= line;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt == TC_LAST) begin
                            tcnt      <= '0;
                            done      <= 1'b1;
                            chr.data  <= shreg[7:0];
                            chr.ferr  <= ~line;
                            chr.perr  <= par_on & ((^shreg) ^ par_bit ^ par_odd);
                            state     <= ST_IDLE;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_errq_fifo.sv
// Module: character queue with a flush input and a fill count.
// Assumes DEPTH is a power of two. A write when full or a read when empty
// is ignored. Flush takes priority over write and read.
module uart_rx_errq_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] fill
);
    localparam int AW = $clog2(DEPTH);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] F_FULL = FW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic          wr;
    logic          rd;

    assign wr    = push && (fill != F_FULL) && !flush;
    assign rd    = pop && (fill != '0) && !flush;
    assign rdata = mem[rptr];

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= wdata;
    end

    // Pointer and fill bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (wr) wptr <= wptr + 1'b1;
            if (rd) rptr <= rptr + 1'b1;
            case ({wr, rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_errq.sv
// Module: receive path top. It selects the input line for loopback, runs the
// deserializer, queues characters with their error verdicts, keeps the
// sticky overrun flag and drives the threshold interrupt.
// Assumes os_tick is produced elsewhere at 16 strobes per bit time.
module uart_rx_errq
    import uart_rx_errq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rx_pin,
    input  logic       lb_en,
    input  logic       lb_tx,
    input  logic       rx_en,
    input  logic [1:0] par_sel,
    input  logic [1:0] irq_sel,
    input  logic       rd_pop,
    input  logic       ovf_clr,
    output logic [7:0] rx_data,
    output logic       data_avail,
    output logic       overrun,
    output logic       parity_err,
    output logic       frame_err,
    output logic       rx_irq
);
    localparam int FW = $clog2(DEPTH + 1);
    localparam logic [FW-1:0] F_FULL = FW'(DEPTH);
    localparam logic [FW-1:0] F_HALF = FW'(DEPTH / 2);
    localparam logic [FW-1:0] F_3Q   = FW'((3 * DEPTH) / 4);
    localparam logic [FW-1:0] F_ONE  = FW'(1);

    logic          line_sel;
    logic          frame_done;
    rx_char_t      new_chr;
    rx_char_t      head;
    logic [FW-1:0] fill_lvl;
    logic          q_full;
    logic          push_ok;
    logic [FW-1:0] irq_lvl;

    assign line_sel = lb_en ? lb_tx : rx_pin;
    assign q_full   = (fill_lvl == F_FULL);
    assign push_ok  = frame_done && !overrun && !q_full && !ovf_clr;

    uart_rx_errq_shift #(.OVS(OVS), .DATA_BITS(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (os_tick),
        .rx_en    (rx_en),
        .line_raw (line_sel),
        .par_sel  (par_sel),
        .done     (frame_done),
        .chr      (new_chr)
    );

    uart_rx_errq_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ovf_clr),
        .push  (push_ok),
        .wdata (new_chr),
        .pop   (rd_pop),
        .rdata (head),
        .fill  (fill_lvl)
    );

    // Sticky overrun: set on a character that finds the queue full
    always_ff @(posedge clk) begin
        if (!rst_n)                                  overrun <= 1'b0;
        else if (ovf_clr)                            overrun <= 1'b0;
        else if (frame_done && q_full)               overrun <= 1'b1;
    end

    // Interrupt threshold picked by the select
    always_comb begin
        case (irq_sel)
            2'b00:   irq_lvl = F_ONE;
            2'b01:   irq_lvl = F_HALF;
            2'b10:   irq_lvl = F_3Q;
            default: irq_lvl = F_FULL;
        endcase
    end

    // Head status outputs, zero while the queue is empty
    assign data_avail = (fill_lvl != '0);
    assign rx_data    = data_avail ? head.data : 8'h00;
    assign parity_err = data_avail & head.perr;
    assign frame_err  = data_avail & head.ferr;
    assign rx_irq     = (fill_lvl >= irq_lvl) && (fill_lvl != '0);

endmodule

// File: rtl/uart_rx_errq_chk.sv
// Checker: temporal properties of the receive path, bound to the top.
// Assumes it sees the top's fill level and its deserializer done pulse.
module uart_rx_errq_chk #(
    parameter int DEPTH = 8,
    parameter int FW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          ovf_clr,
    input logic [1:0]    irq_sel,
    input logic          overrun,
    input logic          data_avail,
    input logic          parity_err,
    input logic          frame_err,
    input logic          rx_irq,
    input logic          frame_done,
    input logic [FW-1:0] fill
);
    assert_ovf_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(fill) == FW'(DEPTH)));

    assert_clear_flushes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr |=> (!overrun && !data_avail));

    assert_no_gain_in_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovf_clr) |=> (fill <= $past(fill)));

    assert_empty_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail |-> (!parity_err && !frame_err));

    assert_irq_any_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel == 2'b00) |-> (rx_irq == data_avail));

    assert_off_no_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_en) |-> !frame_done);

endmodule

bind uart_rx_errq uart_rx_errq_chk #(.DEPTH(DEPTH), .FW(FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .ovf_clr    (ovf_clr),
    .irq_sel    (irq_sel),
    .overrun    (overrun),
    .data_avail (data_avail),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .rx_irq     (rx_irq),
    .frame_done (frame_done),
    .fill       (fill_lvl)
);

// File: tb/tb_uart_rx_errq.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_uart_rx_errq;
    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_pin = 1'b1;
    logic       lb_en = 1'b0;
    logic       lb_tx = 1'b1;
    logic       rx_en = 1'b1;
    logic [1:0] par_sel = 2'b00;
    logic [1:0] irq_sel = 2'b00;
    logic       rd_pop = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] rx_data;
    logic       data_avail, overrun, parity_err, frame_err, rx_irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_errq dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
        .lb_en(lb_en), .lb_tx(lb_tx), .rx_en(rx_en), .par_sel(par_sel),
        .irq_sel(irq_sel), .rd_pop(rd_pop), .ovf_clr(ovf_clr),
        .rx_data(rx_data), .data_avail(data_avail), .overrun(overrun),
        .parity_err(parity_err), .frame_err(frame_err), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic v, input logic use_lb);
        if (use_lb) lb_tx = v; else rx_pin = v;
        repeat (BITC) @(negedge clk);
    endtask

    // Sends one frame; has_par adds a parity bit pbit; stop_v is the stop level
    task automatic send(input logic [7:0] d, input logic has_par, input logic pbit,
                        input logic stop_v, input logic use_lb);
        drive_bit(1'b0, use_lb);
        for (int i = 0; i < 8; i++) drive_bit(d[i], use_lb);
        if (has_par) drive_bit(pbit, use_lb);
        drive_bit(stop_v, use_lb);
        drive_bit(1'b1, use_lb);
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 data_avail", data_avail, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 parity_err", parity_err, 0);
        chk("R1 frame_err", frame_err, 0);
        chk("R1 rx_irq", rx_irq, 0);
    endtask

    task automatic t_basic();
        send(8'hA5, 0, 0, 1, 0);
        send(8'h3C, 0, 0, 1, 0);
        chk("R2 avail", data_avail, 1);
        chk("R2 first byte", rx_data, 8'hA5);
        chk("R12 irq any", rx_irq, 1);
        pop_one();
        chk("R6 second byte", rx_data, 8'h3C);
        pop_one();
        chk("R2 empty after pops", data_avail, 0);
        pop_one();
        chk("R6 pop on empty", data_avail, 0);
    endtask

    task automatic t_glitch();
        rx_pin = 1'b0;
        repeat (4) @(negedge clk);
        rx_pin = 1'b1;
        repeat (40) @(negedge clk);
        chk("R3 glitch ignored", data_avail, 0);
        send(8'h81, 0, 0, 1, 0);
        chk("R3 next frame", rx_data, 8'h81);
        pop_one();
        chk("R3 only one char", data_avail, 0);
    endtask

    task automatic t_parity();
        par_sel = 2'b01;
        send(8'h07, 1, ^8'h07, 1, 0);
        send(8'h07, 1, ~(^8'h07), 1, 0);
        chk("R4 even good perr", parity_err, 0);
        chk("R4 even good data", rx_data, 8'h07);
        pop_one();
        chk("R4 even bad perr", parity_err, 1);
        chk("R6 bad keeps data", rx_data, 8'h07);
        pop_one();
        par_sel = 2'b10;
        send(8'h5A, 1, ~(^8'h5A), 1, 0);
        send(8'h5A, 1, ^8'h5A, 1, 0);
        chk("R4 odd good perr", parity_err, 0);
        pop_one();
        chk("R4 odd bad perr", parity_err, 1);
        pop_one();
        par_sel = 2'b11;
        send(8'h33, 0, 0, 1, 0);
        chk("R4 mode 11 no parity", rx_data, 8'h33);
        chk("R4 mode 11 perr", parity_err, 0);
        pop_one();
        par_sel = 2'b00;
    endtask

    task automatic t_frame();
        send(8'hC3, 0, 0, 0, 0);
        repeat (32) @(negedge clk);
        send(8'h11, 0, 0, 1, 0);
        chk("R5 ferr set", frame_err, 1);
        chk("R5 data kept", rx_data, 8'hC3);
        pop_one();
        chk("R6 ferr per char", frame_err, 0);
        chk("R6 next data", rx_data, 8'h11);
        pop_one();
        chk("R5 no stray char", data_avail, 0);
    endtask

    task automatic t_overrun();
        for (int i = 0; i < 8; i++) send(8'(8'h10 + i), 0, 0, 1, 0);
        chk("R7 eight held no ovf", overrun, 0);
        send(8'hEE, 0, 0, 1, 0);
        chk("R7 overrun set", overrun, 1);
        chk("R7 head unchanged", rx_data, 8'h10);
        pop_one();
        send(8'hDD, 0, 0, 1, 0);
        for (int i = 1; i < 8; i++) begin
            chk("R8 order kept", rx_data, 8'(8'h10 + i));
            pop_one();
        end
        chk("R8 dropped while overrun", data_avail, 0);
        chk("R8 overrun sticky", overrun, 1);
        pulse_clr();
        chk("R9 overrun cleared", overrun, 0);
        send(8'h44, 0, 0, 1, 0);
        send(8'h55, 0, 0, 1, 0);
        chk("R9 resumed", rx_data, 8'h44);
        pulse_clr();
        chk("R9 flush empties", data_avail, 0);
        send(8'h66, 0, 0, 1, 0);
        chk("R9 after flush", rx_data, 8'h66);
        pop_one();
    endtask

    task automatic t_rxen();
        rx_en = 1'b0;
        send(8'h99, 0, 0, 1, 0);
        chk("R10 disabled ignored", data_avail, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        send(8'h9A, 0, 0, 1, 0);
        chk("R10 re-enabled", rx_data, 8'h9A);
        pop_one();
    endtask

    task automatic t_loop();
        lb_en = 1'b1;
        rx_pin = 1'b0;
        repeat (4) @(negedge clk);
        send(8'h6B, 0, 0, 1, 1);
        chk("R11 loopback data", rx_data, 8'h6B);
        pop_one();
        chk("R11 pad ignored", data_avail, 0);
        rx_pin = 1'b1;
        repeat (4) @(negedge clk);
        lb_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_irq();
        irq_sel = 2'b01;
        for (int i = 0; i < 3; i++) send(8'(i), 0, 0, 1, 0);
        chk("R12 below half", rx_irq, 0);
        send(8'h03, 0, 0, 1, 0);
        chk("R12 at half", rx_irq, 1);
        irq_sel = 2'b11;
        @(negedge clk);
        chk("R12 full mode", rx_irq, 0);
        for (int i = 0; i < 4; i++) pop_one();
        irq_sel = 2'b00;
        @(negedge clk);
        chk("R12 empty no irq", rx_irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_glitch();
        t_parity();
        t_frame();
        t_overrun();
        t_rxen();
        t_loop();
        t_irq();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule